// File: doc/BRIEF.md
# Receive Frame FIFO Framer

This block sits between a receive MAC datapath and a host read port. Received bytes arrive one per cycle with a last-byte marker and three error flags. Each accepted frame is stored in a word FIFO as a fixed marker word, a header word holding status and byte length, and the payload packed four bytes to a word. The host drains the FIFO through one 32-bit read port, one word per read strobe.

A counter of complete frames waiting lets the host know whether another frame can be read; while it is non-zero the receive interrupt is raised. A frame that cannot fit in the free space is discarded whole, so the host never sees a partial entry. A FIFO reset request empties the store and holds a busy flag for a fixed number of cycles; any frame in flight across a reset is discarded. The host can also force the frame counter to zero.

Top module: `rxf_framer`

## Requirements
- R1: The first word stored for every frame is the constant 32'h0143414D.
- R2: The second word of a frame holds the byte length in bits 15:0 and status in bits 31:16; status bit 4 (word bit 20) is the CRC error flag, bit 5 (word bit 21) the length error flag, bit 6 (word bit 22) the alignment error flag, bit 7 (word bit 23) is set only when none of the three flags is set, and all other status bits are 0.
- R3: The payload follows as ceil(length/4) words; byte k of the frame sits in bits 8*(k mod 4)+7 down to 8*(k mod 4) of payload word k/4, and unused bytes of the final word are 0.
- R4: The frame count rises by one in the cycle after a frame's last byte is accepted and falls by one in the cycle after the host reads that frame's final payload word; both in one cycle leave it unchanged, and it never falls below 0.
- R5: Asserting count_clr makes the frame count 0 in the next cycle, taking priority over a rise or fall in that cycle.
- R6: rx_irq is 1 exactly when the frame count is non-zero.
- R7: A frame whose marker, header and payload words would exceed the free space of the DEPTH-word store is discarded completely: no word of it becomes readable and the count does not change.
- R8: While the FIFO holds no readable word, rd_data is 0 and a read strobe changes no state.
- R9: A fifo_rst pulse empties the store and zeroes the count in the next cycle; rst_busy then stays 1 for RST_CYCLES cycles, reads return 0 meanwhile, and a frame that is in progress at the request or receives bytes while busy is discarded.
- R10: No word of a frame becomes readable before the cycle after its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| in_last | input | 1 | This byte ends the frame |
| in_err_align | input | 1 | Alignment error, sampled with the last byte |
| in_err_len | input | 1 | Length error, sampled with the last byte |
| in_err_crc | input | 1 | CRC error, sampled with the last byte |
| rd_en | input | 1 | Host read strobe; consumes the word on rd_data |
| rd_data | output | 32 | Word at the head of the FIFO, 0 when empty |
| frame_count | output | CNT_W | Complete frames waiting |
| count_clr | input | 1 | Force the frame count to 0 |
| fifo_rst | input | 1 | Request a FIFO reset |
| rst_busy | output | 1 | FIFO reset in progress |
| rx_irq | output | 1 | Receive interrupt, frames waiting |

## Verification
Two functions can fall in one cycle: the commit of an incoming frame, which raises the count, and the host's read of another frame's final payload word, which lowers it. The bench provokes this by timing reads of a stored frame so that its last word is taken in exactly the cycle the next frame's last byte arrives, and judges that the count stays put while both the old frame drains and the new one becomes readable. A count clear is likewise placed on a frame's last byte, where the clear must win. A behavioural queue model checks rd_data, the count, the interrupt and the busy flag after every edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] RXF_MARKER = 32'h0143414D;

    typedef enum logic [1:0] {
        PH_MARK = 2'd0,
        PH_HEAD = 2'd1,
        PH_BODY = 2'd2
    } rxf_phase_e;

endpackage

// File: rtl/rxf_packer.sv
module rxf_packer #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_last,
    input  logic          in_err_align,
    input  logic          in_err_len,
    input  logic          in_err_crc,
    input  logic          blocked,
    input  logic [AW:0]   free_words,
    output logic          mark_we,
    output logic          data_we,
    output logic [AW-1:0] data_off,
    output logic [31:0]   data_word,
    output logic          head_we,
    output logic [31:0]   head_word,
    output logic          commit,
    output logic [AW:0]   commit_words
);

    typedef struct packed {
        logic [15:0] bcnt;
        logic [31:0] acc;
        logic        drop;
    } pk_t;

    pk_t pk_d, pk_q;

    logic [16:0] n_bytes;
    logic [16:0] need;
    logic        ovf;
    logic        drop_now;
    logic [1:0]  lane;
    logic [31:0] acc_new;
    logic        good;

    always_comb begin
        pk_d         = pk_q;
        mark_we      = 1'b0;
        data_we      = 1'b0;
        head_we      = 1'b0;
        commit       = 1'b0;
        n_bytes      = {1'b0, pk_q.bcnt} + 17'd1;
        need         = 17'd2 + ((n_bytes + 17'd3) >> 2);
        ovf          = (need > {{(16 - AW){1'b0}}, free_words}) || n_bytes[16];
        drop_now     = pk_q.drop || blocked || ovf;
        lane         = pk_q.bcnt[1:0];
        acc_new      = (lane == 2'd0) ? {24'd0, in_byte}
                                      : (pk_q.acc | ({24'd0, in_byte} << {lane, 3'b000}));
        data_off     = AW'(pk_q.bcnt[15:2] + 14'd2);
        data_word    = acc_new;
        good         = !(in_err_align || in_err_len || in_err_crc);
        head_word    = {8'h00, good, in_err_align, in_err_len, in_err_crc, 4'h0, n_bytes[15:0]};
        commit_words = (AW + 1)'(need);

        if (in_valid) begin
            mark_we = (pk_q.bcnt == 16'd0) && !drop_now;
            if ((lane == 2'd3) || in_last) begin
                data_we = !drop_now;
            end
            if (in_last) begin
                head_we = !drop_now;
                commit  = !drop_now;
                pk_d    = '0;
            end else begin
                pk_d.bcnt = n_bytes[16] ? pk_q.bcnt : n_bytes[15:0];
                pk_d.acc  = acc_new;
                pk_d.drop = drop_now;
            end
        end else if (blocked && (pk_q.bcnt != 16'd0)) begin
            pk_d.drop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  logic [31:0]   wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  logic [31:0]   wdata_b,
    input  logic          we_c,
    input  logic [AW-1:0] addr_c,
    input  logic [31:0]   wdata_c,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_word
);

    localparam int DEPTH = 1 << AW;

    logic [31:0] slot_view [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [31:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (we_a && (addr_a == AW'(i))) slot_d = wdata_a;
            if (we_b && (addr_b == AW'(i))) slot_d = wdata_b;
            if (we_c && (addr_c == AW'(i))) slot_d = wdata_c;
        end

        always_ff @(posedge clk) begin
            slot_q <= slot_d;
        end

        assign slot_view[i] = slot_q;
    end

    assign rd_word = slot_view[rd_addr];

endmodule

// File: rtl/rxf_walker.sv
module rxf_walker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        pop,
    input  logic [15:0] head_len,
    output logic        last_pop,
    output logic        at_mark
);

    import rxf_pkg::*;

    typedef struct packed {
        rxf_phase_e  phase;
        logic [15:0] left;
    } wk_t;

    wk_t wk_d, wk_q;

    logic [15:0] body_words;

    always_comb begin
        wk_d       = wk_q;
        last_pop   = 1'b0;
        body_words = 16'(({1'b0, head_len} + 17'd3) >> 2);

        if (flush) begin
            wk_d = '{phase: PH_MARK, left: 16'd0};
        end else if (pop) begin
            case (wk_q.phase)
                PH_MARK: wk_d.phase = PH_HEAD;
                PH_HEAD: begin
                    if (body_words == 16'd0) begin
                        last_pop   = 1'b1;
                        wk_d.phase = PH_MARK;
                    end else begin
                        wk_d.left  = body_words;
                        wk_d.phase = PH_BODY;
                    end
                end
                default: begin
                    wk_d.left = wk_q.left - 16'd1;
                    if (wk_q.left == 16'd1) begin
                        last_pop   = 1'b1;
                        wk_d.phase = PH_MARK;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q <= '{phase: PH_MARK, left: 16'd0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign at_mark = (wk_q.phase == PH_MARK);

endmodule

// File: rtl/rxf_framer.sv
module rxf_framer #(
    parameter int AW         = 6,
    parameter int RST_CYCLES = 4,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic             in_err_align,
    input  logic             in_err_len,
    input  logic             in_err_crc,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] frame_count,
    input  logic             count_clr,
    input  logic             fifo_rst,
    output logic             rst_busy,
    output logic             rx_irq
);

    import rxf_pkg::*;

    localparam int          DEPTH   = 1 << AW;
    localparam int          BW      = $clog2(RST_CYCLES + 1);
    localparam logic [AW:0] DEPTH_W = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [AW:0]      used;
        logic [CNT_W-1:0] cnt;
        logic [BW-1:0]    busy;
    } fr_t;

    fr_t st_d, st_q;

    logic          blocked;
    logic [AW:0]   free_words;
    logic          pop;
    logic          empty;
    logic [31:0]   head;
    logic          last_pop;
    logic          at_mark;

    logic          mark_we, data_we, head_we, commit;
    logic [AW-1:0] data_off;
    logic [31:0]   data_word, head_word;
    logic [AW:0]   commit_words;

    logic [AW:0]   used_w;
    logic [AW-1:0] rd_ptr_w;

    assign rst_busy   = (st_q.busy != '0);
    assign blocked    = fifo_rst || rst_busy;
    assign empty      = (st_q.used == '0);
    assign free_words = DEPTH_W - st_q.used;
    assign pop        = rd_en && !empty && !rst_busy;
    assign rd_data    = (empty || rst_busy) ? 32'd0 : head;

    rxf_packer #(.AW(AW)) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_last      (in_last),
        .in_err_align (in_err_align),
        .in_err_len   (in_err_len),
        .in_err_crc   (in_err_crc),
        .blocked      (blocked),
        .free_words   (free_words),
        .mark_we      (mark_we),
        .data_we      (data_we),
        .data_off     (data_off),
        .data_word    (data_word),
        .head_we      (head_we),
        .head_word    (head_word),
        .commit       (commit),
        .commit_words (commit_words)
    );

    rxf_store #(.AW(AW)) u_store (
        .clk     (clk),
        .we_a    (mark_we),
        .addr_a  (st_q.wr_ptr),
        .wdata_a (RXF_MARKER),
        .we_b    (head_we),
        .addr_b  (st_q.wr_ptr + AW'(1)),
        .wdata_b (head_word),
        .we_c    (data_we),
        .addr_c  (st_q.wr_ptr + data_off),
        .wdata_c (data_word),
        .rd_addr (st_q.rd_ptr),
        .rd_word (head)
    );

    rxf_walker u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (fifo_rst),
        .pop      (pop),
        .head_len (head[15:0]),
        .last_pop (last_pop),
        .at_mark  (at_mark)
    );

    always_comb begin
        st_d = st_q;
        if (fifo_rst) begin
            st_d      = '0;
            st_d.busy = BW'(RST_CYCLES);
        end else begin
            if (rst_busy) begin
                st_d.busy = st_q.busy - 1'b1;
            end
            st_d.rd_ptr = st_q.rd_ptr + AW'(pop);
            st_d.used   = st_q.used - (AW + 1)'(pop);
            if (commit) begin
                st_d.wr_ptr = st_q.wr_ptr + commit_words[AW-1:0];
                st_d.used   = st_d.used + commit_words;
            end
            if (count_clr) begin
                st_d.cnt = '0;
            end else begin
                if (commit && (st_q.cnt != '1)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (last_pop && (st_d.cnt != '0)) begin
                    st_d.cnt = st_d.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_count = st_q.cnt;
    assign rx_irq      = (st_q.cnt != '0);
    assign used_w      = st_q.used;
    assign rd_ptr_w    = st_q.rd_ptr;

endmodule

// File: rtl/rxf_framer_chk.sv
module rxf_framer_chk #(
    parameter int AW    = 6,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [31:0]      rd_data,
    input logic [CNT_W-1:0] frame_count,
    input logic             count_clr,
    input logic             fifo_rst,
    input logic             rst_busy,
    input logic             at_mark,
    input logic [AW:0]      used_w,
    input logic [AW-1:0]    rd_ptr_w
);

    localparam int DEPTH = 1 << AW;

    // R1: a walker at a frame boundary must see the marker at the head
    assert_marker_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (at_mark && (used_w != '0) && !rst_busy) |-> (rd_data == 32'h0143414D));

    // R4: every counted frame still owns at least one unread word
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(frame_count) <= 32'(used_w)));

    // R5
    assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_clr && !fifo_rst) |=> (frame_count == '0));

    // R7
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(used_w) <= DEPTH));

    // R8
    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (used_w == '0)) |=> $stable(rd_ptr_w));

    // R9
    assert_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> (rst_busy && (used_w == '0) && (frame_count == '0)));

    // R9
    assert_busy_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> (rd_data == 32'd0));

endmodule

bind rxf_framer rxf_framer_chk #(.AW(AW), .CNT_W(CNT_W)) u_rxf_framer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .frame_count (frame_count),
    .count_clr   (count_clr),
    .fifo_rst    (fifo_rst),
    .rst_busy    (rst_busy),
    .at_mark     (at_mark),
    .used_w      (used_w),
    .rd_ptr_w    (rd_ptr_w)
);

// File: tb/rxf_framer_bench.sv
`timescale 1ns/1ps
module rxf_framer_bench;

    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;
    localparam int RST_CYCLES = 4;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'd0;
    logic             in_last = 1'b0;
    logic             in_err_align = 1'b0;
    logic             in_err_len = 1'b0;
    logic             in_err_crc = 1'b0;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;
    logic [CNT_W-1:0] frame_count;
    logic             count_clr = 1'b0;
    logic             fifo_rst = 1'b0;
    logic             rst_busy;
    logic             rx_irq;

    always #2 clk = ~clk;

    rxf_framer #(.AW(AW), .RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)) u_rxf_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_last      (in_last),
        .in_err_align (in_err_align),
        .in_err_len   (in_err_len),
        .in_err_crc   (in_err_crc),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .frame_count  (frame_count),
        .count_clr    (count_clr),
        .fifo_rst     (fifo_rst),
        .rst_busy     (rst_busy),
        .rx_irq       (rx_irq)
    );

    // behavioural reference
    int unsigned qw[$];
    bit          ql[$];
    int unsigned fr[$];
    bit          m_drop = 1'b0;
    int          m_cnt  = 0;
    int          m_busy = 0;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string tag      = "R8 reset";

    task automatic chk(input bit ok, input string what, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        int unsigned exp_rd;
        exp_rd = (m_busy == 0 && qw.size() > 0) ? qw[0] : 0;
        chk(rd_data == exp_rd, "rd_data", rd_data, exp_rd);
        chk(int'(frame_count) == m_cnt, "frame_count R4", frame_count, m_cnt);
        chk(rx_irq == (m_cnt != 0), "rx_irq R6", rx_irq, (m_cnt != 0));
        chk(rst_busy == (m_busy > 0), "rst_busy R9", rst_busy, (m_busy > 0));
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit l, input logic [2:0] errs,
                        input bit rd, input bit clr, input bit rst);
        bit blocked, pop, commit, lastpop;
        int free, n, need;
        int unsigned nw[$];
        bit          nl[$];
        in_valid = v; in_byte = b; in_last = l;
        in_err_align = errs[2]; in_err_len = errs[1]; in_err_crc = errs[0];
        rd_en = rd; count_clr = clr; fifo_rst = rst;

        blocked = rst || (m_busy > 0);
        pop     = rd && (qw.size() > 0) && (m_busy == 0);
        free    = DEPTH - qw.size();
        commit  = 1'b0;
        if (v) begin
            fr.push_back(b);
            n    = fr.size();
            need = 2 + (n + 3) / 4;
            if (blocked || need > free) m_drop = 1'b1;
            if (l) begin
                if (!m_drop) begin
                    int unsigned st;
                    st = {errs == 3'b000, errs, 4'h0};
                    commit = 1'b1;
                    nw.push_back(32'h0143414D); nl.push_back(1'b0);
                    nw.push_back((st << 16) | n); nl.push_back(1'b0);
                    for (int k = 0; k < (n + 3) / 4; k++) begin
                        int unsigned w;
                        w = 0;
                        for (int j = 0; j < 4; j++)
                            if (4 * k + j < n) w |= fr[4 * k + j] << (8 * j);
                        nw.push_back(w);
                        nl.push_back(k == (n + 3) / 4 - 1);
                    end
                end
                fr.delete();
                m_drop = 1'b0;
            end
        end else if (blocked && fr.size() > 0) begin
            m_drop = 1'b1;
        end
        lastpop = 1'b0;
        if (pop) begin
            lastpop = ql[0];
            void'(qw.pop_front());
            void'(ql.pop_front());
        end
        if (commit) begin
            foreach (nw[i]) begin qw.push_back(nw[i]); ql.push_back(nl[i]); end
        end
        if (rst) begin
            qw.delete(); ql.delete();
            m_cnt  = 0;
            m_busy = RST_CYCLES;
        end else begin
            if (m_busy > 0) m_busy--;
            if (clr) m_cnt = 0;
            else begin
                if (commit && m_cnt < 255) m_cnt++;
                if (lastpop && m_cnt > 0) m_cnt--;
            end
        end
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic idle(input int n, input bit rd);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'b000, rd, 0, 0);
    endtask

    task automatic send(input int len, input int seed, input logic [2:0] errs, input bit rd);
        for (int i = 0; i < len; i++)
            step(1, 8'((seed * 37 + i * 11) ^ i), i == len - 1, errs, rd, 0, 0);
    endtask

    task automatic drain();
        while (qw.size() > 0) step(0, 8'h00, 0, 3'b000, 1, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        tag = "R8 R6 reset state";
        compare();
        idle(2, 1);

        tag = "R1 R2 R3 R10 good frame";
        send(64, 1, 3'b000, 0);
        chk(rd_data == 32'h0143414D, "R1 marker literal", rd_data, 32'h0143414D);
        step(0, 8'h00, 0, 3'b000, 1, 0, 0);
        chk(rd_data == 32'h00800040, "R2 header literal", rd_data, 32'h00800040);
        drain();

        tag = "R2 R3 error flags and padding";
        send(61, 2, 3'b100, 0);
        send(62, 3, 3'b010, 0);
        send(63, 4, 3'b001, 0);
        send(1, 5, 3'b111, 0);
        drain();

        tag = "R8 empty reads";
        idle(5, 1);

        tag = "R4 commit with final-word read";
        send(4, 6, 3'b000, 0);
        step(1, 8'h11, 0, 3'b000, 0, 0, 0);
        step(1, 8'h22, 0, 3'b000, 0, 0, 0);
        step(1, 8'h33, 0, 3'b000, 1, 0, 0);
        step(1, 8'h44, 0, 3'b000, 1, 0, 0);
        step(1, 8'h55, 1, 3'b000, 1, 0, 0);
        chk(frame_count == 8'd1, "R4 count held", frame_count, 1);
        drain();

        tag = "R5 clear";
        send(9, 7, 3'b000, 0);
        send(10, 8, 3'b000, 0);
        step(0, 8'h00, 0, 3'b000, 0, 1, 0);
        chk(frame_count == 8'd0, "R5 cleared", frame_count, 0);
        tag = "R4 floor at zero";
        drain();
        tag = "R5 clear on last byte";
        step(1, 8'hA5, 0, 3'b000, 0, 0, 0);
        step(1, 8'h5A, 1, 3'b000, 0, 1, 0);
        drain();

        tag = "R7 oversize frame";
        send(300, 9, 3'b000, 0);
        idle(2, 1);
        tag = "R7 exact fit then no room";
        send(248, 10, 3'b000, 0);
        send(1, 11, 3'b000, 0);
        drain();
        tag = "R7 partial fill overflow";
        send(200, 12, 3'b000, 0);
        send(60, 13, 3'b000, 0);
        chk(frame_count == 8'd1, "R7 count after drop", frame_count, 1);
        idle(20, 1);
        send(20, 14, 3'b000, 0);
        drain();

        tag = "R9 reset mid frame";
        send(8, 15, 3'b000, 0);
        for (int i = 0; i < 10; i++)
            step(1, 8'(i + 3), i == 9, 3'b000, i == 7, 0, i == 4);
        idle(2, 1);
        tag = "R9 reset during pause";
        send(12, 16, 3'b000, 0);
        send(3, 17, 3'b000, 0);
        step(0, 8'h00, 0, 3'b000, 0, 0, 1);
        idle(RST_CYCLES + 1, 0);
        send(5, 18, 3'b000, 0);
        idle(1, 0);
        send(7, 19, 3'b000, 0);
        drain();

        tag = "R3 R4 R7 mixed traffic";
        for (int f = 0; f < 60; f++) begin
            int len;
            len = 1 + ($urandom % 70);
            for (int i = 0; i < len; i++)
                step(1, 8'($urandom), i == len - 1, 3'($urandom), ($urandom % 2) == 0, 0, 0);
            idle($urandom % 3, 1);
        end
        drain();
        idle(3, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule